// File: doc/BRIEF.md
# Byte-Addressed Word Memory Port

This block is a small synchronous data store for a processor load/store unit. It holds 32-bit words and gives every byte its own address, so consecutive words sit four addresses apart. One request per clock is presented with an operation code, a 32-bit byte address, a 32-bit store value and an endianness select. The block serves whole-word loads and stores, and single-byte loads and stores.

The endianness select is sampled with each request and decides which byte lane of a word a byte offset names. In little-endian mode offset 0 is the low byte. In big-endian mode offset 0 is the high byte. A word address covers the same four bytes in both modes, and a whole word is stored and returned with the same bit order in both.

Loads are registered, so the result appears one clock after the request. A word access whose address is not a multiple of four is refused and raises a fault flag for one cycle. The depth in words is a parameter and must be a power of two. Address bits above the array are ignored.

Top module: `bytemem_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rdata_o` is 0 and `fault_o` is 0.
- R2: The operation codes are 00 load word, 01 store word, 10 load byte and 11 store byte. After a word store, a word load from the same aligned address returns the stored 32-bit value on `rdata_o` one clock after the load request.
- R3: A word load or word store (op bit 1 = 0) with address bits [1:0] not 00 sets `fault_o` to 1 in the following cycle only. It leaves memory unchanged and leaves `rdata_o` unchanged.
- R4: Byte loads and byte stores accept any address and never raise `fault_o`.
- R5: With `big_endian_i` = 0, byte offset k (address bits [1:0]) names word bits [8k+7:8k].
- R6: With `big_endian_i` = 1, byte offset k names word bits [31-8k:24-8k]. A stored 0x23456789 read back by a byte load at address 1 gives 0x45 in this mode and 0x67 in little-endian mode.
- R7: A byte load returns the selected byte in `rdata_o[7:0]`, with bits [31:8] equal to 0.
- R8: A byte store writes `wdata_i[7:0]` into the selected lane only. The other three bytes of that word keep their values, and `wdata_i[31:8]` is ignored.
- R9: Only address bits [log2(WORDS)+1:0] are used. Two addresses that differ only above those bits reach the same byte.
- R10: A cycle with `req_i` = 0 changes neither memory nor `rdata_o`, and it leaves `fault_o` at 0 in the next cycle.
- R11: Stores that complete without a fault do not change `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one operation per cycle |
| op_i | input | 2 | Operation: 00 load word, 01 store word, 10 load byte, 11 store byte |
| big_endian_i | input | 1 | 1 selects big-endian byte numbering for this request |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store value (byte stores use bits [7:0]) |
| rdata_o | output | 32 | Registered load result |
| fault_o | output | 1 | Misaligned word access, one cycle after the request |

## Verification
The bench sweeps every byte address in both endian modes after filling the array with distinct words. A swapped lane mapping therefore shows up as wrong bytes, and missing zero extension shows up as stray upper bits. Byte stores are swept over every address with junk in the upper store bits, each followed by a word readback. This catches a store that writes the whole word, the wrong lane, or the wrong source bits. Misaligned word loads and stores are issued at every offset of every word. A design that still wrote memory, updated the read register or skipped the fault would fail the next aligned readback. Addresses carrying high bits, and idle cycles carrying store inputs, expose any use of address bits above the array and any missing qualification by `req_i`.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        OP_LDW = 2'b00,
        OP_STW = 2'b01,
        OP_LDB = 2'b10,
        OP_STB = 2'b11
    } mem_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              fault;
    } port_state_t;

endpackage

// File: rtl/bytemem_decode.sv
module bytemem_decode
    import bytemem_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              req_i,
    input  logic [1:0]        op_i,
    input  logic              big_endian_i,
    input  logic [31:0]       addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [LANES-1:0]  lane_we_o,
    output logic [LANES-1:0]  lane_sel_o,
    output logic              word_op_o,
    output logic              load_ok_o,
    output logic              fault_o
);

    mem_op_e    op;
    logic [1:0] offset;
    logic [1:0] lane;
    logic       is_store;
    logic       misaligned;
    logic       accept;
    logic       unused_addr_hi;

    assign idx_o          = addr_i[IDX_W+1:2];
    assign unused_addr_hi = ^addr_i[31:IDX_W+2];

    always_comb begin
        op         = mem_op_e'(op_i);
        offset     = addr_i[1:0];
        // lane index counts from the least significant byte
        lane       = big_endian_i ? (2'd3 - offset) : offset;
        word_op_o  = (op == OP_LDW) || (op == OP_STW);
        is_store   = (op == OP_STW) || (op == OP_STB);
        misaligned = word_op_o && (offset != 2'b00);
        accept     = req_i && !misaligned;
        fault_o    = req_i && misaligned;
        load_ok_o  = accept && !is_store;
        for (int k = 0; k < LANES; k++) begin
            lane_sel_o[k] = (lane == 2'(k));
        end
        lane_we_o = '0;
        if (accept && is_store) begin
            lane_we_o = word_op_o ? '1 : lane_sel_o;
        end
    end

endmodule

// File: rtl/bytemem_wsteer.sv
module bytemem_wsteer
    import bytemem_pkg::*;
(
    input  logic              word_op_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] lane_data_o
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_data_o[k*BYTE_W +: BYTE_W] =
            word_op_i ? wdata_i[k*BYTE_W +: BYTE_W] : wdata_i[BYTE_W-1:0];
    end

endmodule

// File: rtl/bytemem_lane.sv
module bytemem_lane
    import bytemem_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] wbyte_i,
    output logic [BYTE_W-1:0] rbyte_o
);

    logic [BYTE_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[idx_i] <= wbyte_i;
        end
    end

    assign rbyte_o = mem_q[idx_i];

endmodule

// File: rtl/bytemem_port.sv
module bytemem_port
    import bytemem_pkg::*;
#(
    parameter int WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic [1:0]  op_i,
    input  logic        big_endian_i,
    input  logic [31:0] addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        fault_o
);

    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [IDX_W-1:0]  idx;
    logic [LANES-1:0]  lane_we;
    logic [LANES-1:0]  lane_sel;
    logic              word_op;
    logic              load_ok;
    logic              fault;
    logic [WORD_W-1:0] lane_wdata;
    logic [WORD_W-1:0] rd_word;
    logic [BYTE_W-1:0] rd_byte;

    port_state_t st_d, st_q;

    bytemem_decode #(.IDX_W(IDX_W)) u_decode (
        .req_i        (req_i),
        .op_i         (op_i),
        .big_endian_i (big_endian_i),
        .addr_i       (addr_i),
        .idx_o        (idx),
        .lane_we_o    (lane_we),
        .lane_sel_o   (lane_sel),
        .word_op_o    (word_op),
        .load_ok_o    (load_ok),
        .fault_o      (fault)
    );

    bytemem_wsteer u_wsteer (
        .word_op_i   (word_op),
        .wdata_i     (wdata_i),
        .lane_data_o (lane_wdata)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        bytemem_lane #(.WORDS(WORDS), .IDX_W(IDX_W)) u_lane (
            .clk     (clk),
            .we_i    (lane_we[k]),
            .idx_i   (idx),
            .wbyte_i (lane_wdata[k*BYTE_W +: BYTE_W]),
            .rbyte_o (rd_word[k*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_sel[k]) begin
                rd_byte = rd_byte | rd_word[k*BYTE_W +: BYTE_W];
            end
        end
        st_d       = st_q;
        st_d.fault = fault;
        if (load_ok) begin
            st_d.rdata = word_op ? rd_word : {{(WORD_W-BYTE_W){1'b0}}, rd_byte};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign fault_o = st_q.fault;

endmodule

// File: rtl/bytemem_port_chk.sv
module bytemem_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic [1:0]  op_i,
    input logic [31:0] addr_i,
    input logic [31:0] rdata_o,
    input logic        fault_o
);

    // R3: a fault only follows a misaligned word request
    a_r3_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(req_i && !op_i[1] && (addr_i[1:0] != 2'b00)));

    // R4: byte operations never fault
    a_r4_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_i && op_i[1]) |-> !fault_o);

    // R7: byte load result is zero extended
    a_r7_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_i && (op_i == 2'b10)) |-> (rdata_o[31:8] == 24'h0));

    // R10: result register changes only after an accepted load (also R3, R11)
    a_r10_hold_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_i && !op_i[0] && !(!op_i[1] && (addr_i[1:0] != 2'b00)))
        |-> $stable(rdata_o));

    // R10: an idle cycle is never followed by a fault
    a_r10_idle_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!req_i) |-> !fault_o);

endmodule

bind bytemem_port bytemem_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .op_i    (op_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o),
    .fault_o (fault_o)
);

// File: tb/bytemem_port_test.sv
module bytemem_port_test;

    localparam int WORDS = 16;
    localparam int BYTES = WORDS * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic        big_endian_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        fault_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] model [WORDS];

    always #2 clk = ~clk;

    bytemem_port #(.WORDS(WORDS)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .op_i         (op_i),
        .big_endian_i (big_endian_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .rdata_o      (rdata_o),
        .fault_o      (fault_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one request, then outputs are sampled at the following falling edge
    task automatic issue(input logic [1:0] op, input logic [31:0] addr,
                         input logic [31:0] wd, input logic be);
        @(negedge clk);
        req_i = 1'b1; op_i = op; addr_i = addr; wdata_i = wd; big_endian_i = be;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input int a, input logic be);
        int w   = (a / 4) % WORDS;
        int off = a % 4;
        int ln  = be ? (3 - off) : off;
        return 8'((model[w] >> (8 * ln)) & 32'hFF);
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", rdata_o, 32'h0);
        check("R1 fault in reset", {31'h0, fault_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", rdata_o, 32'h0);

        // fill all words, stores must not disturb rdata (R11)
        for (int i = 0; i < WORDS; i++) begin
            model[i] = (32'(i) * 32'h0102_0408) ^ 32'hC3A5_5A3C;
            issue(2'b01, 32'(i * 4), model[i], i[0]);
            check("R11 store keeps rdata", rdata_o, 32'h0);
            check("R4 store word no fault", {31'h0, fault_o}, 32'h0);
        end
        for (int i = 0; i < WORDS; i++) begin
            issue(2'b00, 32'(i * 4), 32'hDEAD_BEEF, i[1]);
            check("R2 word readback", rdata_o, model[i]);
        end

        // worked example of lane numbering
        model[0] = 32'h2345_6789;
        issue(2'b01, 32'h0, model[0], 1'b0);
        issue(2'b10, 32'h1, 32'h0, 1'b0);
        check("R5 little endian offset 1", rdata_o, 32'h67);
        issue(2'b10, 32'h1, 32'h0, 1'b1);
        check("R6 big endian offset 1", rdata_o, 32'h45);

        // byte load sweep, both modes (R4 R5 R6 R7)
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < BYTES; a++) begin
                issue(2'b10, 32'(a), 32'hFFFF_FFFF, m[0]);
                check(m == 0 ? "R5 R7 byte load LE" : "R6 R7 byte load BE",
                      rdata_o, {24'h0, exp_byte(a, m[0])});
                check("R4 byte load no fault", {31'h0, fault_o}, 32'h0);
            end
        end

        // byte store sweep with junk upper bits (R8)
        for (int a = 0; a < BYTES; a++) begin
            logic       be;
            logic [7:0] v;
            int         ln;
            be = a[2] ^ a[0];
            v  = 8'(a) ^ 8'h5A;
            ln = be ? (3 - (a % 4)) : (a % 4);
            model[a / 4][8 * ln +: 8] = v;
            issue(2'b11, 32'(a), {24'hA5C3E1, v}, be);
            check("R4 byte store no fault", {31'h0, fault_o}, 32'h0);
            issue(2'b00, 32'(a & ~3), 32'h0, 1'b0);
            check("R8 byte store one lane", rdata_o, model[a / 4]);
        end

        // misaligned word accesses (R3)
        for (int i = 0; i < WORDS; i++) begin
            for (int off = 1; off < 4; off++) begin
                held = rdata_o;
                issue(2'b00, 32'(i * 4 + off), 32'h0, off[0]);
                check("R3 load fault flag", {31'h0, fault_o}, 32'h1);
                check("R3 load keeps rdata", rdata_o, held);
                issue(2'b01, 32'(i * 4 + off), ~model[i], off[1]);
                check("R3 store fault flag", {31'h0, fault_o}, 32'h1);
                check("R3 store keeps rdata", rdata_o, held);
                @(negedge clk);
                check("R3 fault lasts one cycle", {31'h0, fault_o}, 32'h0);
            end
            issue(2'b00, 32'(i * 4), 32'h0, 1'b0);
            check("R3 memory unchanged", rdata_o, model[i]);
        end

        // high address bits ignored (R9)
        for (int i = 0; i < WORDS; i++) begin
            logic [31:0] hi;
            hi = (32'(i) * 32'h9E37_79B9) & ~32'(BYTES - 1);
            model[i] = 32'h0F1E_2D3C + 32'(i);
            issue(2'b01, hi | 32'(i * 4), model[i], 1'b0);
            issue(2'b00, 32'(i * 4), 32'h0, 1'b0);
            check("R9 store wraps", rdata_o, model[i]);
            issue(2'b10, (hi ^ 32'hFFFF_FF00) | 32'(i * 4 + 2), 32'h0, 1'b1);
            check("R9 byte load wraps", rdata_o, {24'h0, exp_byte(i * 4 + 2, 1'b1)});
        end

        // idle cycles with store inputs present (R10)
        held = rdata_o;
        @(negedge clk);
        req_i = 1'b0; op_i = 2'b01; addr_i = 32'h8; wdata_i = 32'hFFFF_FFFF;
        @(negedge clk);
        op_i = 2'b00; addr_i = 32'h3;
        @(negedge clk);
        check("R10 idle keeps rdata", rdata_o, held);
        check("R10 idle no fault", {31'h0, fault_o}, 32'h0);
        issue(2'b00, 32'h8, 32'h0, 1'b0);
        check("R10 idle store ignored", rdata_o, model[2]);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule